// File: doc/BRIEF.md
# Micro-op Dispatch Slot Controller

This block sits between decode and the out-of-order back end. Each cycle it looks at up to W decoded candidates, presented in program order, and decides which of them move on. W is a fixed budget of slots counted in micro-ops. The block keeps no instruction storage. A candidate is taken only when it can be handed to the next stage in that same cycle. Taking stops at the first candidate that cannot go.

An instruction whose micro-op count exceeds W uses the whole budget in its first cycle. The surplus is held in a carry-over counter and drained in the cycles that follow, with a continuation report each cycle. Begin-group and end-group markers force alignment:
- A begin-group instruction needs a completely fresh budget.
- An end-group instruction closes the budget for the rest of its cycle.

Reorder-buffer space, free rename registers and downstream readiness arrive as inputs. Allocation amounts leave as outputs. A failed reorder-buffer check and a failed register check each raise their own stall-cause flag.

Top module: `uop_dispatch_ctrl`

## Requirements
- R1: After synchronous reset the carry-over is zero, no continuation is reported and the first cycle offers all W slots, so W one-micro-op candidates are all taken.
- R2: `take` bit i may be set only if `in_valid` bit i is set and every lower lane is also taken; the first refused candidate ends the cycle's acceptance.
- R3: A candidate is refused when no slots remain or when min(micro-ops, W) exceeds the slots remaining. An accepted candidate of at most W micro-ops uses exactly its micro-op count. Its `take_uops` field (bits i*UW +: UW) reports that count.
- R4: A candidate with its `in_begin` bit set is taken only if all W slots are still free in the current cycle.
- R5: Taking a candidate with more than W micro-ops uses every remaining slot and stores a carry-over of (micro-ops − W). Its `take_uops` field reports W.
- R6: At the start of a cycle with carry-over C > 0, `cont_valid` is 1 and `cont_uops` is min(C, W). The cycle then offers W − min(C, W) slots, and C drops by min(C, W). No candidate is taken while C ≥ W.
- R7: After a candidate with its `in_end` bit set is taken, no further candidate is taken in that cycle.
- R8: The running sum of full micro-op counts of taken candidates never exceeds `rob_free`, and `rob_alloc` equals that sum. `stall_rob` is 1 when the first refused candidate passed the slot and group checks but failed this one.
- R9: The running sum of destination counts of taken candidates never exceeds `reg_free`, and `reg_alloc` equals that sum. `stall_reg` is 1 when the first refused candidate passed the slot and group checks but failed this one.
- R10: While `next_ready` is 0 no candidate is taken.
- R11: With `DISP_W` set to 0 the budget and lane count equal `ISSUE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LN | Candidate present, lane 0 oldest |
| in_uops | input | LN*UW | Micro-op count per lane |
| in_ndst | input | LN*DW | Destination register count per lane |
| in_begin | input | LN | Begin-group marker per lane |
| in_end | input | LN | End-group marker per lane |
| rob_free | input | RBW | Free reorder-buffer entries |
| reg_free | input | RGW | Free rename registers |
| next_ready | input | 1 | Downstream stage can accept |
| take | output | LN | Lanes dispatched this cycle |
| take_uops | output | LN*UW | Reported micro-ops per taken lane |
| rob_alloc | output | RBW | Reorder-buffer entries allocated |
| reg_alloc | output | RGW | Rename registers allocated |
| cont_valid | output | 1 | Continuation of a spilled instruction reported |
| cont_uops | output | UW | Micro-ops in that continuation |
| stall_rob | output | 1 | Refusal caused by reorder-buffer space |
| stall_reg | output | 1 | Refusal caused by rename registers |
| carry_busy | output | 1 | Carry-over pending at cycle start |

## Verification
The assertions take for granted that `rob_free` and `reg_free` report the true free counts during the cycle in which they are used. They also assume that a micro-op count fits in UW bits, so an oversized spill leaves a carry below 2^UW. The bench keeps every micro-op count within 0..15 and drives all inputs on the falling edge. Free counts are chosen so that both the tight and the loose cases of each cumulative check occur. Begin and end markers and `next_ready` drop-outs are mixed in at fixed low rates, so the checks meet begin, end and not-ready cases together with carry-over drains.

// File: rtl/uop_dispatch_ctrl.sv
module uop_dispatch_ctrl #(
  parameter int DISP_W  = 4,
  parameter int ISSUE_W = 4,
  parameter int UW      = 4,
  parameter int DW      = 2,
  parameter int RBW     = 6,
  parameter int RGW     = 6,
  localparam int LN     = (DISP_W == 0) ? ISSUE_W : DISP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LN-1:0]    in_valid,
  input  logic [LN*UW-1:0] in_uops,
  input  logic [LN*DW-1:0] in_ndst,
  input  logic [LN-1:0]    in_begin,
  input  logic [LN-1:0]    in_end,
  input  logic [RBW-1:0]   rob_free,
  input  logic [RGW-1:0]   reg_free,
  input  logic             next_ready,
  output logic [LN-1:0]    take,
  output logic [LN*UW-1:0] take_uops,
  output logic [RBW-1:0]   rob_alloc,
  output logic [RGW-1:0]   reg_alloc,
  output logic             cont_valid,
  output logic [UW-1:0]    cont_uops,
  output logic             stall_rob,
  output logic             stall_reg,
  output logic             carry_busy
);

  logic [UW-1:0] carry, carry_nxt;
  int            cont_n;

  assign cont_n     = (int'(carry) > LN) ? LN : int'(carry);
  assign cont_valid = carry != '0;
  assign cont_uops  = UW'(cont_n);
  assign carry_busy = carry != '0;

  always_comb begin
    int   s, rc, gc, u, d, req;
    logic go, slot_ok, rob_ok, reg_ok, ov;
    int   ovc;
    s = LN - cont_n;
    rc = 0;
    gc = 0;
    go = 1'b1;
    ov = 1'b0;
    ovc = 0;
    take = '0;
    take_uops = '0;
    stall_rob = 1'b0;
    stall_reg = 1'b0;
    for (int i = 0; i < LN; i++) begin
      u = int'(in_uops[i*UW +: UW]);
      d = int'(in_ndst[i*DW +: DW]);
      req = (u > LN) ? LN : u;
      slot_ok = in_valid[i] && (s != 0) && (req <= s) && (!in_begin[i] || s == LN);
      rob_ok  = (rc + u) <= int'(rob_free);
      reg_ok  = (gc + d) <= int'(reg_free);
      if (go) begin
        if (slot_ok && rob_ok && reg_ok && next_ready) begin
          take[i] = 1'b1;
          take_uops[i*UW +: UW] = UW'(req);
          rc = rc + u;
          gc = gc + d;
          if (u > LN) begin
            ov = 1'b1;
            ovc = u - LN;
            s = 0;
          end else begin
            s = s - u;
          end
          if (in_end[i]) s = 0;
        end else begin
          go = 1'b0;
          if (slot_ok) begin
            stall_rob = !rob_ok;
            stall_reg = !reg_ok;
          end
        end
      end
    end
    rob_alloc = RBW'(rc);
    reg_alloc = RGW'(gc);
    carry_nxt = ov ? UW'(ovc) : UW'(int'(carry) - cont_n);
  end

  always_ff @(posedge clk) begin
    if (rst) carry <= '0;
    else     carry <= carry_nxt;
  end

  p_valid_only_r2: assert property (@(posedge clk) disable iff (rst)
    (take & ~in_valid) == '0);
  p_spill_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(carry) >= LN) |-> (take == '0));
  p_rob_bound_r8: assert property (@(posedge clk) disable iff (rst)
    rob_alloc <= rob_free);
  p_reg_bound_r9: assert property (@(posedge clk) disable iff (rst)
    reg_alloc <= reg_free);
  p_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    !next_ready |-> (take == '0));
  p_spill_cont_r5: assert property (@(posedge clk) disable iff (rst)
    (take[0] && int'(in_uops[UW-1:0]) > LN) |=> cont_valid);

endmodule

// File: tb/uop_dispatch_ctrl_tb.sv
module uop_dispatch_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 0, rst = 1;
  always #(CLK_P/2) clk = ~clk;

  logic [3:0]  iv, ib, ie;
  logic [15:0] iu;
  logic [7:0]  idst;
  logic [5:0]  rf, gf;
  logic        nr;
  logic [3:0]  tk;
  logic [15:0] tu;
  logic [5:0]  ra, ga;
  logic        cv, sr, sg, cb;
  logic [3:0]  cu;

  uop_dispatch_ctrl u_dut (
    .clk(clk), .rst(rst), .in_valid(iv), .in_uops(iu), .in_ndst(idst),
    .in_begin(ib), .in_end(ie), .rob_free(rf), .reg_free(gf), .next_ready(nr),
    .take(tk), .take_uops(tu), .rob_alloc(ra), .reg_alloc(ga),
    .cont_valid(cv), .cont_uops(cu), .stall_rob(sr), .stall_reg(sg), .carry_busy(cb));

  logic [1:0] zv, zb, ze, ztk;
  logic [7:0] zu, ztu;
  logic [3:0] zd;
  logic [5:0] zra, zga;
  logic       zcv, zsr, zsg, zcb;
  logic [3:0] zcu;

  uop_dispatch_ctrl #(.DISP_W(0), .ISSUE_W(2)) u_dut_z (
    .clk(clk), .rst(rst), .in_valid(zv), .in_uops(zu), .in_ndst(zd),
    .in_begin(zb), .in_end(ze), .rob_free(6'd63), .reg_free(6'd63), .next_ready(1'b1),
    .take(ztk), .take_uops(ztu), .rob_alloc(zra), .reg_alloc(zga),
    .cont_valid(zcv), .cont_uops(zcu), .stall_rob(zsr), .stall_reg(zsg), .carry_busy(zcb));

  int checks = 0, errors = 0;
  int mc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    iv = 0; ib = 0; ie = 0; iu = 0; idst = 0; rf = 63; gf = 63; nr = 1;
  endtask

  task automatic step();
    int s, rc, gc, cont, ovc;
    bit go, ov;
    logic [3:0] et;
    logic [15:0] eu;
    bit esr, esg;
    #1;
    cont = (mc > W) ? W : mc;
    s = W - cont; rc = 0; gc = 0; go = 1; ov = 0; ovc = 0;
    et = 0; eu = 0; esr = 0; esg = 0;
    for (int i = 0; i < W; i++) begin
      int u, d, req;
      bit so, ro, go2;
      u = int'(iu[i*4 +: 4]);
      d = int'(idst[i*2 +: 2]);
      req = (u > W) ? W : u;
      so = iv[i] && s != 0 && req <= s && (!ib[i] || s == W);
      ro = rc + u <= int'(rf);
      go2 = gc + d <= int'(gf);
      if (go) begin
        if (so && ro && go2 && nr) begin
          et[i] = 1; eu[i*4 +: 4] = 4'(req); rc += u; gc += d;
          if (u > W) begin ov = 1; ovc = u - W; s = 0; end else s -= u;
          if (ie[i]) s = 0;
        end else begin
          go = 0;
          if (so) begin esr = !ro; esg = !go2; end
        end
      end
    end
    chk(tk == et, "R2 take", tk, et);
    chk(tu == eu, "R3 take_uops", tu, eu);
    chk(cv == (mc != 0) && int'(cu) == cont, "R6 continuation", cu, cont);
    chk(int'(ra) == rc && sr == esr, "R8 rob", {sr, ra}, {esr, 6'(rc)});
    chk(int'(ga) == gc && sg == esg, "R9 regs", {sg, ga}, {esg, 6'(gc)});
    mc = ov ? ovc : mc - cont;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    zv = 0; zb = 0; ze = 0; zu = 0; zd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: full budget after reset
    iv = 4'hF; iu = 16'h1111; #1;
    chk(cv == 0, "R1 no continuation", cv, 0);
    chk(tk == 4'hF, "R1 full budget", tk, 15);
    step();

    // R4: begin-group needs fresh budget
    idle(); iv = 4'h3; iu = 16'h0011; ib = 4'h2; #1;
    chk(tk == 4'h1, "R4 begin refused mid-cycle", tk, 1);
    step();
    idle(); iv = 4'h1; iu = 16'h0004; ib = 4'h1; #1;
    chk(tk == 4'h1, "R4 begin accepted fresh", tk, 1);
    step();

    // R7: end-group closes cycle
    idle(); iv = 4'h3; iu = 16'h0011; ie = 4'h1; #1;
    chk(tk == 4'h1, "R7 end closes", tk, 1);
    step();

    // R5/R6: oversize spill of 10 uops
    idle(); iv = 4'h3; iu = 16'h001A; #1;
    chk(tk == 4'h1 && tu[3:0] == 4'd4, "R5 spill first report", tu[3:0], 4);
    step();
    idle(); iv = 4'h1; iu = 16'h0001; #1;
    chk(cv && cu == 4'd4 && tk == 0, "R6 full continuation blocks", {cu, tk}, {4'd4, 4'd0});
    step();
    idle(); iv = 4'h7; iu = 16'h0111; #1;
    chk(cu == 4'd2 && tk == 4'h3, "R6 partial continuation", {cu, tk}, {4'd2, 4'd3});
    step();

    // R10
    idle(); iv = 4'hF; iu = 16'h1111; nr = 0; #1;
    chk(tk == 0, "R10 not ready", tk, 0);
    step();

    // R8/R9 tight limits
    idle(); iv = 4'h3; iu = 16'h0022; rf = 3; #1;
    chk(tk == 4'h1 && sr, "R8 rob stall", {sr, tk}, 5'h11);
    step();
    idle(); iv = 4'h3; iu = 16'h0011; idst = 8'h0A; gf = 3; #1;
    chk(tk == 4'h1 && sg, "R9 reg stall", {sg, tk}, 5'h11);
    step();

    // R11: zero width selects issue width 2
    idle();
    zv = 2'b11; zu = 8'h11; #1;
    chk(ztk == 2'b11, "R11 two lanes", ztk, 3);
    @(posedge clk); @(negedge clk);
    zv = 2'b01; zu = 8'h03; #1;
    chk(ztk == 2'b01 && ztu[3:0] == 4'd2, "R11 budget two", ztu[3:0], 2);
    @(posedge clk); @(negedge clk);
    zv = 2'b01; zu = 8'h01; #1;
    chk(zcu == 4'd1 && ztk == 2'b01, "R11 carry of one", {zcu, ztk}, {4'd1, 2'b01});
    @(posedge clk); @(negedge clk);
    zv = 0;

    // sweep
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < W; i++) begin
        iu[i*4 +: 4] = ($urandom % 4 != 0) ? 4'(1 + $urandom % 3) : 4'($urandom % 16);
        idst[i*2 +: 2] = 2'($urandom % 4);
        ib[i] = ($urandom % 6) == 0;
        ie[i] = ($urandom % 6) == 0;
        iv[i] = ($urandom % 8) != 0;
      end
      rf = ($urandom % 2) ? 6'($urandom % 12) : 6'd63;
      gf = ($urandom % 2) ? 6'($urandom % 8) : 6'd63;
      nr = ($urandom % 8) != 0;
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule